// File: doc/BRIEF.md
# Biphase Remote-Control Frame Transmitter

This block turns a key press into a repeating infrared remote-control frame. A 5-bit system code and a 6-bit command code are captured when a frame is launched. They are serialised with two leading ones and a toggle flag into a 14-bit frame that uses biphase (Manchester) coding. The frame leaves the block on two outputs. One is the baseband level. The other is the same level gated by a carrier taken from the oscillator clock, which runs at the block's `clk`. Each output has its own enable, and both enables are low whenever no frame is on the air, so the pins can be tri-stated by the pad ring.

A frame starts on the first clock after `key_held` is seen high while the block is idle. While the key stays down, a new frame starts every `REPEAT_BITS` bit-times, counted from the start of the previous one. Between frames the outputs are tri-stated. A frame that has begun always runs to its end. Releasing the key only stops the next repeat.

The toggle flag tells a receiver whether a frame belongs to a fresh press or repeats the same press. It flips on every new press and holds across repeats.

Top module: `ir_frame_tx`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `data_oe`, `mod_oe`, `data_out` and `mod_out` are all 0. The toggle state resets to 0.
- R2: The frame is 14 bits, sent in this order: bit 13 = 1, bit 12 = 1, bit 11 = toggle, bits 10..6 = system code from its MSB down, bits 5..0 = command code from its MSB down.
- R3: Each bit lasts two half-bits of `HALF_CYC` clocks (384 by default, 768 per bit). A 1 is sent low then high, and a 0 is sent high then low. This means the first start bit begins with a low half.
- R4: `data_oe` and `mod_oe` go high on the first clock after `key_held` is sampled high in idle. They stay high for exactly 28 half-bits and then go low. `data_out` and `mod_out` are 0 whenever the enables are low.
- R5: `mod_out` equals `data_out` AND a carrier of period `CARRIER_DIV` clocks (12 by default). The carrier is high for the first half of each period. Its phase restarts at each frame start, so clock j of a frame (j counted from 0) has the carrier high when j mod 12 < 6.
- R6: While `key_held` stays high, the next frame starts exactly 2·`REPEAT_BITS` half-bits (64 bit-times by default) after the previous frame started. The outputs are tri-stated in between.
- R7: The toggle bit inverts on every new press, so the first frame after reset carries 1. It keeps its value in every repeat of the same press.
- R8: If the key is released during a frame, that frame still completes unchanged. The outputs then stay tri-stated and no repeat follows.
- R9: If the key is released in the gap between frames, no further frame is sent. A later press launches on the next clock with an inverted toggle.
- R10: The system and command codes are captured when a frame starts. Changing them during a frame has no effect on that frame, and a repeat carries the codes present at its own start.
- R11: If the key is released and pressed again within one frame, the next frame at the repeat point counts as a new press, so its toggle is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all timing is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| key_held | input | 1 | High while a key is pressed (already debounced) |
| sys_code | input | 5 | System address, captured at frame start |
| cmd_code | input | 6 | Command number, captured at frame start |
| data_out | output | 1 | Baseband biphase level |
| data_oe | output | 1 | Output enable for `data_out` |
| mod_out | output | 1 | Biphase level gated by the divided carrier |
| mod_oe | output | 1 | Output enable for `mod_out` |

## Verification
The hardest states to reach are the ones where the key changes at a precise moment relative to the frame timing. These include a release on the last clock of a frame, a release a few clocks into the gap, and a release and re-press that both fall inside one frame. The last case must change the toggle decision at the next repeat point without disturbing the frame in flight. The bench counts clocks from the launch edge and changes `key_held` on chosen frame and gap offsets, both directed and drawn at random. It then compares every clock of both outputs against a level and carrier computed from the frame word and the clock offset.

// File: rtl/ir_tx_pkg.sv
// Shared definitions for the biphase frame transmitter.
// Assumes: frame header is two start ones followed by one toggle bit.
package ir_tx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_GAP  = 2'd2
    } tx_state_e;

    localparam int HDR_BITS = 3;

endpackage

// File: rtl/ir_half_timer.sv
// Half-bit timer: counts clocks within a half-bit and half-bits within
// the repeat window. Assumes restart has priority and that the window
// is never longer than 2**HI_W half-bits.
module ir_half_timer #(
    parameter int HALF_CYC = 384,
    parameter int HI_W     = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            run,
    output logic            half_end,
    output logic [HI_W-1:0] half_idx
);
    localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

    logic [HC_W-1:0] hc;

    assign half_end = run && (hc == HC_LAST);

    // Advance the clock and half-bit counters while a frame window runs.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            hc       <= '0;
            half_idx <= '0;
        end else if (hc == HC_LAST) begin
            hc       <= '0;
            half_idx <= half_idx + 1'b1;
        end else begin
            hc <= hc + 1'b1;
        end
    end

    assert_half_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && hc == HC_LAST) |=> (half_idx == HI_W'($past(half_idx) + 1'b1)));

    assert_half_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && hc != HC_LAST) |=> $stable(half_idx));

endmodule

// File: rtl/ir_carrier_gen.sv
// Carrier divider: produces a 50 % duty carrier of CARRIER_DIV clocks.
// Assumes CARRIER_DIV is even; phase is restarted at each frame launch.
module ir_carrier_gen #(
    parameter int CARRIER_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic carrier
);
    localparam int CC_W = $clog2(CARRIER_DIV);
    localparam logic [CC_W-1:0] CC_LAST = CC_W'(CARRIER_DIV - 1);
    localparam logic [CC_W-1:0] CC_HALF = CC_W'(CARRIER_DIV / 2);

    logic [CC_W-1:0] cc;

    assign carrier = (cc < CC_HALF);

    // Free-running modulo counter, zeroed at reset and on launch.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cc <= '0;
        end else if (cc == CC_LAST) begin
            cc <= '0;
        end else begin
            cc <= cc + 1'b1;
        end
    end

    assert_carrier_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cc <= CC_LAST);

    assert_carrier_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> carrier);

endmodule

// File: rtl/ir_frame_ctrl.sv
// Frame controller: decides when frames launch, keeps the toggle flag
// and latches the frame word. Assumes key_held is already debounced and
// that the repeat window is longer than one frame.
module ir_frame_ctrl
    import ir_tx_pkg::*;
#(
    parameter int SYS_W       = 5,
    parameter int CMD_W       = 6,
    parameter int FRAME_BITS  = 14,
    parameter int WIN_HALVES  = 128,
    parameter int HI_W        = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  key_held,
    input  logic [SYS_W-1:0]      sys_code,
    input  logic [CMD_W-1:0]      cmd_code,
    input  logic                  half_end,
    input  logic [HI_W-1:0]       half_idx,
    output tx_state_e             state,
    output logic                  launch,
    output logic [FRAME_BITS-1:0] frame_word
);
    localparam logic [HI_W-1:0] FRAME_LAST = HI_W'(2 * FRAME_BITS - 1);
    localparam logic [HI_W-1:0] WIN_LAST   = HI_W'(WIN_HALVES - 1);

    logic      toggle;
    logic      held;
    logic      next_toggle;
    logic      frame_done;
    logic      window_done;
    tx_state_e state_nx;

    assign frame_done  = (state == TX_SEND) && half_end && (half_idx == FRAME_LAST);
    assign window_done = (state == TX_GAP) && half_end && (half_idx == WIN_LAST);
    assign launch      = key_held && ((state == TX_IDLE) || window_done);
    assign next_toggle = held ? toggle : ~toggle;

    // Next-state choice for idle, frame and gap phases.
    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE: if (launch) state_nx = TX_SEND;
            TX_SEND: if (frame_done) state_nx = key_held ? TX_GAP : TX_IDLE;
            TX_GAP: begin
                if (!key_held)   state_nx = TX_IDLE;
                else if (launch) state_nx = TX_SEND;
            end
            default: state_nx = TX_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    // Track whether the key has stayed down since the last launch.
    always_ff @(posedge clk) begin
        if (!rst_n || !key_held) held <= 1'b0;
        else if (launch)         held <= 1'b1;
    end

    // Update the toggle flag and capture the frame word at each launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            toggle     <= 1'b0;
            frame_word <= '0;
        end else if (launch) begin
            toggle     <= next_toggle;
            frame_word <= {2'b11, next_toggle, sys_code, cmd_code};
        end
    end

    assert_frame_completes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SEND && !frame_done) |=> (state == TX_SEND));

    assert_toggle_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && held) |=> (frame_word[FRAME_BITS-HDR_BITS] == $past(toggle)));

    assert_toggle_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !held) |=> (frame_word[FRAME_BITS-HDR_BITS] != $past(toggle)));

    assert_gap_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_GAP && !key_held) |=> (state == TX_IDLE));

endmodule

// File: rtl/ir_biphase_out.sv
// Output stage: maps the frame word and half-bit index to the biphase
// level, gates it with the carrier and drives the enables.
// Assumes half_idx < 2*FRAME_BITS whenever a frame is being sent.
module ir_biphase_out #(
    parameter int FRAME_BITS = 14,
    parameter int HI_W       = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sending,
    input  logic [FRAME_BITS-1:0] frame_word,
    input  logic [HI_W-1:0]       half_idx,
    input  logic                  carrier,
    output logic                  data_out,
    output logic                  data_oe,
    output logic                  mod_out,
    output logic                  mod_oe
);
    int   bit_pos;
    logic bit_val;
    logic level;

    // Select the current bit (MSB first) and its level in this half.
    always_comb begin
        bit_pos = int'(half_idx >> 1);
        bit_val = 1'b0;
        if (bit_pos < FRAME_BITS) bit_val = frame_word[FRAME_BITS-1-bit_pos];
        level = half_idx[0] ? bit_val : ~bit_val;
    end

    assign data_oe  = sending;
    assign mod_oe   = sending;
    assign data_out = sending & level;
    assign mod_out  = sending & level & carrier;

    assert_mod_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mod_out |-> (data_out && data_oe));

    assert_start_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && half_idx == HI_W'(1)) |-> data_out);

    assert_quiet_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_oe |-> (!data_out && !mod_out));

endmodule

// File: rtl/ir_frame_tx.sv
// Top level of the biphase frame transmitter: joins timer, carrier,
// controller and output stage. Assumes clk is the oscillator clock and
// REPEAT_BITS exceeds the frame length.
module ir_frame_tx
    import ir_tx_pkg::*;
#(
    parameter int SYS_W       = 5,
    parameter int CMD_W       = 6,
    parameter int HALF_CYC    = 384,
    parameter int CARRIER_DIV = 12,
    parameter int REPEAT_BITS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_held,
    input  logic [SYS_W-1:0] sys_code,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             data_out,
    output logic             data_oe,
    output logic             mod_out,
    output logic             mod_oe
);
    localparam int FRAME_BITS = HDR_BITS + SYS_W + CMD_W;
    localparam int WIN_HALVES = 2 * REPEAT_BITS;
    localparam int HI_W       = $clog2(WIN_HALVES);

    tx_state_e             state;
    logic                  launch;
    logic                  half_end;
    logic [HI_W-1:0]       half_idx;
    logic                  carrier;
    logic [FRAME_BITS-1:0] frame_word;

    ir_half_timer #(
        .HALF_CYC (HALF_CYC),
        .HI_W     (HI_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (launch),
        .run      (state != TX_IDLE),
        .half_end (half_end),
        .half_idx (half_idx)
    );

    ir_carrier_gen #(
        .CARRIER_DIV (CARRIER_DIV)
    ) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch),
        .carrier (carrier)
    );

    ir_frame_ctrl #(
        .SYS_W      (SYS_W),
        .CMD_W      (CMD_W),
        .FRAME_BITS (FRAME_BITS),
        .WIN_HALVES (WIN_HALVES),
        .HI_W       (HI_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_held   (key_held),
        .sys_code   (sys_code),
        .cmd_code   (cmd_code),
        .half_end   (half_end),
        .half_idx   (half_idx),
        .state      (state),
        .launch     (launch),
        .frame_word (frame_word)
    );

    ir_biphase_out #(
        .FRAME_BITS (FRAME_BITS),
        .HI_W       (HI_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .sending    (state == TX_SEND),
        .frame_word (frame_word),
        .half_idx   (half_idx),
        .carrier    (carrier),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .mod_out    (mod_out),
        .mod_oe     (mod_oe)
    );

    assert_launch_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && key_held) |=> (data_oe && mod_oe));

endmodule

// File: tb/ir_frame_tx_test.sv
module ir_frame_tx_test;
    localparam int HALF = 24;
    localparam int DIV  = 12;
    localparam int REP  = 32;
    localparam int FH   = 28;
    localparam int WIN  = 2 * REP * HALF;
    localparam int GAP  = (2 * REP - FH) * HALF;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       key_held;
    logic [4:0] sys_code;
    logic [5:0] cmd_code;
    logic       data_out, data_oe, mod_out, mod_oe;

    always #5 clk = ~clk;

    ir_frame_tx #(.HALF_CYC(HALF), .CARRIER_DIV(DIV), .REPEAT_BITS(REP)) uut (
        .clk(clk), .rst_n(rst_n), .key_held(key_held),
        .sys_code(sys_code), .cmd_code(cmd_code),
        .data_out(data_out), .data_oe(data_oe),
        .mod_out(mod_out), .mod_oe(mod_oe)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit exp_tog = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [13:0] mk(input bit t, input logic [4:0] s, input logic [5:0] c);
        return {2'b11, t, s, c};
    endfunction

    function automatic bit exp_level(input logic [13:0] w, input int j);
        int h = j / HALF;
        bit b = w[13 - h / 2];
        return (h % 2 == 0) ? ~b : b;
    endfunction

    function automatic bit exp_car(input int j);
        return (j % DIV) < (DIV / 2);
    endfunction

    // Watches one frame from its first clock; may drive key or codes on given offsets.
    task automatic watch_frame(input logic [13:0] w, input int rel_at, input int rep_at,
                               input int chg_at, input string tag);
        int bad_oe = 0, bad_d = 0, bad_m = 0;
        int first_d = -1;
        for (int j = 0; j < FH * HALF; j++) begin
            bit lv = exp_level(w, j);
            if (data_oe !== 1'b1 || mod_oe !== 1'b1) bad_oe++;
            if (data_out !== lv) begin
                if (first_d < 0) first_d = j;
                bad_d++;
            end
            if (mod_out !== (lv & exp_car(j))) bad_m++;
            if (j == rel_at) key_held = 1'b0;
            if (j == rep_at) key_held = 1'b1;
            if (j == chg_at) begin
                sys_code = 5'($urandom);
                cmd_code = 6'($urandom);
            end
            @(negedge clk);
        end
        chk(bad_oe == 0, "R4", {"enables during frame ", tag}, bad_oe, 0);
        chk(bad_d == 0, "R2 R3", {"data level mismatches ", tag}, bad_d, 0);
        if (first_d >= 0) $display("  first data mismatch at clock %0d of frame %h", first_d, w);
        chk(bad_m == 0, "R5", {"carrier-gated mismatches ", tag}, bad_m, 0);
    endtask

    // Watches n clocks in which all outputs must be quiet.
    task automatic watch_quiet(input int n, input int rel_at, input string req, input string tag);
        int bad = 0;
        for (int j = 0; j < n; j++) begin
            if (data_oe !== 1'b0 || mod_oe !== 1'b0 || data_out !== 1'b0 || mod_out !== 1'b0) bad++;
            if (j == rel_at) key_held = 1'b0;
            @(negedge clk);
        end
        chk(bad == 0, req, {"outputs quiet ", tag}, bad, 0);
    endtask

    task automatic press();
        key_held = 1'b1;
        exp_tog  = ~exp_tog;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [13:0] w;
        void'($urandom(32'd2024));
        rst_n = 1'b0; key_held = 1'b0; sys_code = '0; cmd_code = '0;
        repeat (4) @(negedge clk);
        chk({data_oe, mod_oe, data_out, mod_out} == 4'b0, "R1", "outputs in reset",
            int'({data_oe, mod_oe, data_out, mod_out}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({data_oe, mod_oe, data_out, mod_out} == 4'b0, "R1", "outputs after reset",
            int'({data_oe, mod_oe, data_out, mod_out}), 0);

        // R10 / R6 / R7: codes change mid-frame; repeat carries new codes, same toggle.
        sys_code = 5'h15; cmd_code = 6'h2A;
        press();
        w = mk(exp_tog, 5'h15, 6'h2A);
        chk(w[11] == 1'b1, "R7", "first toggle after reset", int'(w[11]), 1);
        watch_frame(w, -1, -1, 100, "R10 first");
        watch_quiet(GAP, -1, "R6", "repeat gap");
        watch_frame(mk(exp_tog, sys_code, cmd_code), 60, -1, -1, "R6 R7 R10 repeat");
        watch_quiet(WIN + 50, -1, "R8", "after mid-frame release");

        // Boundary codes, release on last frame clock and on first clock.
        sys_code = 5'h00; cmd_code = 6'h00;
        press();
        watch_frame(mk(exp_tog, 5'h00, 6'h00), FH * HALF - 1, -1, -1, "zeros R8 last clock");
        watch_quiet(WIN, -1, "R8", "after last-clock release");
        sys_code = 5'h1F; cmd_code = 6'h3F;
        press();
        watch_frame(mk(exp_tog, 5'h1F, 6'h3F), 0, -1, -1, "ones R7 toggle");
        watch_quiet(WIN, -1, "R8", "after first-clock release");

        // R9: release in gap, then immediate new press.
        sys_code = 5'h0A; cmd_code = 6'h15;
        press();
        watch_frame(mk(exp_tog, 5'h0A, 6'h15), -1, -1, -1, "R9 held");
        watch_quiet(GAP + 200, 10, "R9", "release in gap");
        press();
        watch_frame(mk(exp_tog, 5'h0A, 6'h15), 5, -1, -1, "R9 R7 new press");
        watch_quiet(WIN, -1, "R8", "after R9 press");

        // R11: release and re-press within one frame.
        sys_code = 5'h13; cmd_code = 6'h0C;
        press();
        watch_frame(mk(exp_tog, 5'h13, 6'h0C), 40, 80, -1, "R11 bounce");
        watch_quiet(GAP, -1, "R11", "gap after bounce");
        exp_tog = ~exp_tog;
        watch_frame(mk(exp_tog, 5'h13, 6'h0C), 30, -1, -1, "R11 R7 toggle flipped");
        watch_quiet(WIN, -1, "R8", "after R11");

        // Random presses with releases in frame, in repeat, or in gap.
        for (int it = 0; it < 8; it++) begin
            int mode = int'($urandom % 3);
            int at   = int'($urandom % (FH * HALF));
            logic [4:0] s = 5'($urandom);
            logic [5:0] c = 6'($urandom);
            sys_code = s; cmd_code = c;
            press();
            if (mode == 0) begin
                watch_frame(mk(exp_tog, s, c), at, -1, -1, "random R8");
                watch_quiet(WIN, -1, "R8", "random after frame");
            end else if (mode == 1) begin
                watch_frame(mk(exp_tog, s, c), -1, -1, -1, "random R6");
                watch_quiet(GAP, -1, "R6", "random gap");
                watch_frame(mk(exp_tog, s, c), at, -1, -1, "random R7 repeat");
                watch_quiet(WIN, -1, "R8", "random after repeat");
            end else begin
                watch_frame(mk(exp_tog, s, c), -1, -1, -1, "random R9");
                watch_quiet(GAP + 100, at % GAP, "R9", "random gap release");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule